// File: doc/BRIEF.md
# Power-Domain Switch Sequencer

This block gates power to one switchable logic domain. It runs from a slow reference clock. Software uses a small register bus to ask for the domain to collapse (power off) or to restore (power on). A hardware state machine then performs the steps in a fixed order.

To power up, the machine closes a small group of head switches first, then closes the remaining switches. After that it releases the I/O clamp and the domain reset, and last it enables the domain clock. To power down, it stops the clock, applies the clamp and reset, and then opens every switch. Each wait step lasts 2^n reference cycles, with n programmable per step. Every sequence starts with a fixed startup window, and the status bit only changes once the sequence has completed.

A hardware-trigger mode lets an external request line take the place of the software collapse bit. A software override drives the switches straight from the collapse bit. Retention controls and a manual clamp or reset-pulse register are passed through to the domain.

Top module: `pds_switch_seq`

## Requirements
- R1: After reset the domain is on: few_en_o, rest_en_o and clk_en_o are 1; clamp_o and dom_rst_o are 0. The control register (offset 0x0) reads 0x8000_0000. The config register (offset 0x4) reads 0x0001_0000.
- R2: Control register at offset 0x0 has these fields:
  - bit 0: collapse request (1 means off).
  - bit 1: hardware-trigger mode.
  - bit 2: software override.
  - [23:20]: rest-switch wait.
  - [19:16]: few-switch wait.
  - [15:12]: clock-off wait.
  - bit 31: read-only power-on status.
  The writable fields read back as written.
- R3: A wait field holding n makes its step last exactly 2^n reference cycles, for n from 0 to 15.
- R4: Power-down timing. Take the clock edge that captures the collapse write as edge 0. clk_en_o falls after edge 9. clamp_o and dom_rst_o rise after edge 9+2^c. Both switch enables fall after edge 10+2^c. Here c is the clock-off wait.
- R5: Power-up timing. Take the write edge as edge 0. few_en_o rises after edge 9 and rest_en_o after edge 9+2^f. clamp_o and dom_rst_o fall after edge 9+2^f+2^r. clk_en_o rises after edge 10+2^f+2^r. Here f is the few-switch wait and r is the rest-switch wait.
- R6: Every sequence begins with an 8-cycle startup window. Status bit 31 keeps its old value until the sequence completes, and changes in the same cycle as the last output step.
- R7: Config register bit 16 is the power-up-complete flag and bit 15 is the power-down-complete flag. Both flags are read-only. When a sequence starts, the flag for the state being left clears. When the sequence completes, the flag for the state reached sets.
- R8: While the override bit is set, the switch, clock and clamp outputs follow the collapse bit in the cycle after the write, with no waits. The status bit and the flags follow one cycle later. Clearing the override starts no sequence.
- R9: A request that changes during a running sequence does not alter it. When the sequence ends, the state machine acts on the current request.
- R10: In hardware-trigger mode the input hw_req replaces the collapse bit, and the collapse bit has no effect.
- R11: Changing the hardware-trigger bit while the domain is on runs one full power-down followed by a power-up.
- R12: Config bit 11 drives ret_ff_o. Retention register bit 14 (offset 0x8) drives ret_mem_o, and bit 13 of the same register drives ret_periph_o.
- R13: In the clamp register (offset 0xC), bit 0 forces clamp_o. Writing 1 to bit 4 gives a one-cycle dom_rst_o pulse, and bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_req | input | 1 | Hardware collapse request (1 means off) |
| few_en_o | output | 1 | First head-switch group enable |
| rest_en_o | output | 1 | Remaining head-switch enable |
| clamp_o | output | 1 | Domain I/O clamp |
| dom_rst_o | output | 1 | Domain reset |
| clk_en_o | output | 1 | Domain clock enable |
| ret_ff_o | output | 1 | Flip-flop retention enable |
| ret_mem_o | output | 1 | Memory retention |
| ret_periph_o | output | 1 | Peripheral retention |

## Verification
A fault in the wait counter or in the sequencer state shows up as an output edge in the wrong cycle. For example, clk_en_o might rise while clamp_o is still high, or the switches might open before the clamp is applied. Such errors appear within the first 9 to 30 cycles after a request, and the sweep over wait values pins each edge to the exact cycle. A status or flag register that updates too early shows as bit 31 changing during the startup window. A stuck request path shows as a domain that never leaves its state, or that leaves it when the request should be ignored.

// File: rtl/pds_pkg.sv
package pds_pkg;
    localparam int DATA_W = 32;
    localparam int WAIT_W = 4;
    localparam int CNT_W  = 1 << WAIT_W;

    localparam int OFS_CTRL  = 'h0;
    localparam int OFS_CFG   = 'h4;
    localparam int OFS_RET   = 'h8;
    localparam int OFS_CLAMP = 'hC;

    localparam int B_COLLAPSE = 0;
    localparam int B_HWMODE   = 1;
    localparam int B_OVR      = 2;
    localparam int B_STATUS   = 31;
    localparam int B_PU_DONE  = 16;
    localparam int B_PD_DONE  = 15;
    localparam int B_RET_FF   = 11;
    localparam int B_RET_MEM  = 14;
    localparam int B_RET_PER  = 13;
    localparam int B_MCLAMP   = 0;
    localparam int B_RPULSE   = 4;

    typedef enum logic [2:0] {
        S_ON, S_OFF, S_START, S_PD_CLK, S_PD_CLAMP, S_PU_FEW, S_PU_REST, S_PU_REL
    } seq_state_e;

    typedef struct packed {
        logic              collapse;
        logic              hw_mode;
        logic              ovr;
        logic [WAIT_W-1:0] w_rest;
        logic [WAIT_W-1:0] w_few;
        logic [WAIT_W-1:0] w_clk;
    } ctrl_t;

    typedef struct packed {
        logic few;
        logic rest;
        logic clamp;
        logic rst;
        logic clk;
    } dom_out_t;

    function automatic logic [CNT_W-1:0] wait_load(input logic [WAIT_W-1:0] n);
        return (CNT_W'(1) << n) - CNT_W'(1);
    endfunction
endpackage

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pwr_on,
    input  logic              pu_done,
    input  logic              pd_done,
    output ctrl_t             ctrl,
    output logic              mode_tgl,
    output logic              ret_ff,
    output logic              ret_mem,
    output logic              ret_per,
    output logic              man_clamp,
    output logic              rst_pulse
);
    logic sel_ctrl, sel_cfg, sel_ret, sel_clamp;

    assign sel_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    assign sel_cfg   = (addr == ADDR_W'(OFS_CFG));
    assign sel_ret   = (addr == ADDR_W'(OFS_RET));
    assign sel_clamp = (addr == ADDR_W'(OFS_CLAMP));

    assign mode_tgl = wr && sel_ctrl && (wdata[B_HWMODE] != ctrl.hw_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            ret_ff    <= 1'b0;
            ret_mem   <= 1'b0;
            ret_per   <= 1'b0;
            man_clamp <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= wr && sel_clamp && wdata[B_RPULSE];
            if (wr && sel_ctrl) begin
                ctrl.collapse <= wdata[B_COLLAPSE];
                ctrl.hw_mode  <= wdata[B_HWMODE];
                ctrl.ovr      <= wdata[B_OVR];
                ctrl.w_rest   <= wdata[23:20];
                ctrl.w_few    <= wdata[19:16];
                ctrl.w_clk    <= wdata[15:12];
            end
            if (wr && sel_cfg) ret_ff <= wdata[B_RET_FF];
            if (wr && sel_ret) begin
                ret_mem <= wdata[B_RET_MEM];
                ret_per <= wdata[B_RET_PER];
            end
            if (wr && sel_clamp) man_clamp <= wdata[B_MCLAMP];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[B_STATUS]   = pwr_on;
            rdata[23:20]      = ctrl.w_rest;
            rdata[19:16]      = ctrl.w_few;
            rdata[15:12]      = ctrl.w_clk;
            rdata[B_OVR]      = ctrl.ovr;
            rdata[B_HWMODE]   = ctrl.hw_mode;
            rdata[B_COLLAPSE] = ctrl.collapse;
        end else if (sel_cfg) begin
            rdata[B_PU_DONE] = pu_done;
            rdata[B_PD_DONE] = pd_done;
            rdata[B_RET_FF]  = ret_ff;
        end else if (sel_ret) begin
            rdata[B_RET_MEM] = ret_mem;
            rdata[B_RET_PER] = ret_per;
        end else if (sel_clamp) begin
            rdata[B_MCLAMP] = man_clamp;
        end
    end

    // R13: a reset pulse only follows a write of bit 4 to the clamp register
    assert_rst_pulse_src_R13: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> $past(wr && sel_clamp && wdata[B_RPULSE]));
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int STARTUP_CYC = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  ctrl_t    ctrl,
    input  logic     hw_req,
    input  logic     mode_tgl,
    output dom_out_t seq,
    output logic     pwr_on,
    output logic     pu_done,
    output logic     pd_done
);
    localparam logic [CNT_W-1:0] START_LOAD = CNT_W'(STARTUP_CYC - 1);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             go_down;
    logic             cyc_pend;
    logic             want_off;
    logic             cnt_zero;

    assign want_off = ctrl.hw_mode ? hw_req : ctrl.collapse;
    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_ON;
            cnt      <= '0;
            go_down  <= 1'b0;
            cyc_pend <= 1'b0;
            pwr_on   <= 1'b1;
            pu_done  <= 1'b1;
            pd_done  <= 1'b0;
        end else if (ctrl.ovr) begin
            st       <= ctrl.collapse ? S_OFF : S_ON;
            cnt      <= '0;
            cyc_pend <= 1'b0;
            pwr_on   <= !ctrl.collapse;
            pu_done  <= !ctrl.collapse;
            pd_done  <= ctrl.collapse;
        end else begin
            if (mode_tgl && st == S_ON) cyc_pend <= 1'b1;
            case (st)
                S_ON: if (want_off || cyc_pend) begin
                    st      <= S_START;
                    cnt     <= START_LOAD;
                    go_down <= 1'b1;
                    pu_done <= 1'b0;
                end
                S_OFF: if (!want_off || cyc_pend) begin
                    st       <= S_START;
                    cnt      <= START_LOAD;
                    go_down  <= 1'b0;
                    pd_done  <= 1'b0;
                    cyc_pend <= 1'b0;
                end
                S_START: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                    else if (go_down) begin
                        st  <= S_PD_CLK;
                        cnt <= wait_load(ctrl.w_clk);
                    end else begin
                        st  <= S_PU_FEW;
                        cnt <= wait_load(ctrl.w_few);
                    end
                end
                S_PD_CLK: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                    else st <= S_PD_CLAMP;
                end
                S_PD_CLAMP: begin
                    st      <= S_OFF;
                    pwr_on  <= 1'b0;
                    pd_done <= 1'b1;
                end
                S_PU_FEW: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                    else begin
                        st  <= S_PU_REST;
                        cnt <= wait_load(ctrl.w_rest);
                    end
                end
                S_PU_REST: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                    else st <= S_PU_REL;
                end
                S_PU_REL: begin
                    st      <= S_ON;
                    pwr_on  <= 1'b1;
                    pu_done <= 1'b1;
                end
                default: st <= S_ON;
            endcase
        end
    end

    always_comb begin
        seq = '0;
        case (st)
            S_ON:       begin seq.few = 1'b1; seq.rest = 1'b1; seq.clk = 1'b1; end
            S_OFF:      begin seq.clamp = 1'b1; seq.rst = 1'b1; end
            S_START: begin
                seq.few   = go_down;
                seq.rest  = go_down;
                seq.clk   = go_down;
                seq.clamp = !go_down;
                seq.rst   = !go_down;
            end
            S_PD_CLK:   begin seq.few = 1'b1; seq.rest = 1'b1; end
            S_PD_CLAMP: begin seq.few = 1'b1; seq.rest = 1'b1; seq.clamp = 1'b1; seq.rst = 1'b1; end
            S_PU_FEW:   begin seq.few = 1'b1; seq.clamp = 1'b1; seq.rst = 1'b1; end
            S_PU_REST:  begin seq.few = 1'b1; seq.rest = 1'b1; seq.clamp = 1'b1; seq.rst = 1'b1; end
            S_PU_REL:   begin seq.few = 1'b1; seq.rest = 1'b1; end
            default:    seq = '0;
        endcase
    end

    // R4: the clock runs only with every switch closed and the clamp released
    assert_clk_needs_power_R4: assert property (@(posedge clk) disable iff (rst)
        seq.clk |-> (seq.few && seq.rest && !seq.clamp));

    // R5: the rest group never closes without the first group
    assert_rest_after_few_R5: assert property (@(posedge clk) disable iff (rst)
        seq.rest |-> seq.few);

    // R6: status turns on only at the end of a power-up sequence
    assert_status_rise_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwr_on) && !$past(ctrl.ovr)) |-> ($past(st) == S_PU_REL));

    // R6: status turns off only at the end of a power-down sequence
    assert_status_fall_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwr_on) && !$past(ctrl.ovr)) |-> ($past(st) == S_PD_CLAMP));

    // R7: the two completion flags are never set together
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $countones({pu_done, pd_done}) <= 1);
endmodule

// File: rtl/pds_outmux.sv
module pds_outmux
    import pds_pkg::*;
(
    input  logic     ovr,
    input  logic     collapse,
    input  dom_out_t seq,
    input  logic     man_clamp,
    input  logic     rst_pulse,
    output logic     few_en,
    output logic     rest_en,
    output logic     clamp,
    output logic     dom_rst,
    output logic     clk_en
);
    dom_out_t sel;

    always_comb begin
        if (ovr) begin
            sel.few   = !collapse;
            sel.rest  = !collapse;
            sel.clk   = !collapse;
            sel.clamp = collapse;
            sel.rst   = collapse;
        end else begin
            sel = seq;
        end
    end

    assign few_en  = sel.few;
    assign rest_en = sel.rest;
    assign clk_en  = sel.clk;
    assign clamp   = sel.clamp | man_clamp;
    assign dom_rst = sel.rst | rst_pulse;
endmodule

// File: rtl/pds_switch_seq.sv
module pds_switch_seq
    import pds_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int STARTUP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              hw_req,
    output logic              few_en_o,
    output logic              rest_en_o,
    output logic              clamp_o,
    output logic              dom_rst_o,
    output logic              clk_en_o,
    output logic              ret_ff_o,
    output logic              ret_mem_o,
    output logic              ret_periph_o
);
    ctrl_t    ctrl;
    dom_out_t seq;
    logic     mode_tgl, man_clamp, rst_pulse;
    logic     pwr_on, pu_done, pd_done;

    pds_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .pwr_on(pwr_on), .pu_done(pu_done), .pd_done(pd_done),
        .ctrl(ctrl), .mode_tgl(mode_tgl), .ret_ff(ret_ff_o), .ret_mem(ret_mem_o),
        .ret_per(ret_periph_o), .man_clamp(man_clamp), .rst_pulse(rst_pulse)
    );

    pds_fsm #(.STARTUP_CYC(STARTUP_CYC)) u_fsm (
        .clk(clk), .rst(rst), .ctrl(ctrl), .hw_req(hw_req), .mode_tgl(mode_tgl),
        .seq(seq), .pwr_on(pwr_on), .pu_done(pu_done), .pd_done(pd_done)
    );

    pds_outmux u_out (
        .ovr(ctrl.ovr), .collapse(ctrl.collapse), .seq(seq), .man_clamp(man_clamp),
        .rst_pulse(rst_pulse), .few_en(few_en_o), .rest_en(rest_en_o),
        .clamp(clamp_o), .dom_rst(dom_rst_o), .clk_en(clk_en_o)
    );
endmodule

// File: tb/pds_switch_seq_tb.sv
`timescale 1ns/1ps
module pds_switch_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_req = 1'b0;
    logic        few, rest, clamp, drst, clken, rff, rmem, rper;

    int errors = 0;
    int total  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pds_switch_seq u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_req(hw_req),
        .few_en_o(few), .rest_en_o(rest), .clamp_o(clamp), .dom_rst_o(drst),
        .clk_en_o(clken), .ret_ff_o(rff), .ret_mem_o(rmem), .ret_periph_o(rper)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // write; returns at the falling edge right after the capturing edge (k = 0)
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 4'h0;
    endtask

    function automatic logic [31:0] ctl(input int r, input int f, input int c, input logic [2:0] low);
        return (32'(r) << 20) | (32'(f) << 16) | (32'(c) << 12) | 32'(low);
    endfunction

    task automatic run_down(input int r, input int f, input int c, input int len);
        int t_clk = -1, t_clamp = -1, t_sw = -1, t_stat = -1;
        logic [31:0] d;
        wr(4'h0, ctl(r, f, c, 3'b001));
        for (int k = 0; k < len; k++) begin
            if (k > 0) begin @(negedge clk); #1; end
            if (!clken && t_clk < 0) t_clk = k;
            if (clamp && drst && t_clamp < 0) t_clamp = k;
            if (!few && !rest && t_sw < 0) t_sw = k;
            if (!bus_rdata[31] && t_stat < 0) t_stat = k;
        end
        chk("R4 clk_en fall cycle", t_clk, 9);
        chk("R3 R4 clamp rise cycle", t_clamp, 9 + (1 << c));
        chk("R4 switches open cycle", t_sw, 10 + (1 << c));
        chk("R6 status off cycle", t_stat, 10 + (1 << c));
        rd(4'h4, d);
        chk("R7 flags after power-down", d[16:15], 2'b01);
    endtask

    task automatic run_up(input int r, input int f, input int c, input int len);
        int t_few = -1, t_rest = -1, t_rel = -1, t_clk = -1, t_stat = -1;
        logic [31:0] d;
        wr(4'h0, ctl(r, f, c, 3'b000));
        for (int k = 0; k < len; k++) begin
            if (k > 0) begin @(negedge clk); #1; end
            if (few && t_few < 0) t_few = k;
            if (rest && t_rest < 0) t_rest = k;
            if (!clamp && !drst && t_rel < 0) t_rel = k;
            if (clken && t_clk < 0) t_clk = k;
            if (bus_rdata[31] && t_stat < 0) t_stat = k;
        end
        chk("R5 few rise cycle", t_few, 9);
        chk("R3 R5 rest rise cycle", t_rest, 9 + (1 << f));
        chk("R5 clamp release cycle", t_rel, 9 + (1 << f) + (1 << r));
        chk("R5 clk_en rise cycle", t_clk, 10 + (1 << f) + (1 << r));
        chk("R6 status on cycle", t_stat, 10 + (1 << f) + (1 << r));
        rd(4'h4, d);
        chk("R7 flags after power-up", d[16:15], 2'b10);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; total++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int t_off, t_on;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 switch/clock outputs", {few, rest, clken}, 3'b111);
        chk("R1 clamp/reset outputs", {clamp, drst}, 2'b00);
        rd(4'h0, d); chk("R1 control reset value", d, 32'h8000_0000);
        rd(4'h4, d); chk("R1 config reset value", d, 32'h0001_0000);

        // R2 readback of fields (collapse 0 so domain stays on)
        wr(4'h0, 32'h00A5_3000);
        rd(4'h0, d); chk("R2 control readback", d, 32'h80A5_3000);
        chk("R2 domain still on", {few, clken}, 2'b11);

        // R13 manual clamp and reset pulse
        wr(4'hC, 32'h1);
        chk("R13 manual clamp", clamp, 1);
        chk("R13 switches unaffected", few, 1);
        wr(4'hC, 32'h10);
        chk("R13 reset pulse high", drst, 1);
        @(negedge clk); #1;
        chk("R13 reset pulse one cycle", drst, 0);
        chk("R13 clamp released", clamp, 0);
        rd(4'hC, d); chk("R13 clamp reg reads", d, 0);

        // R12 retention
        wr(4'h4, 32'h800);
        chk("R12 ret_ff_o", rff, 1);
        rd(4'h4, d); chk("R12 config readback", d, 32'h0001_0800);
        wr(4'h8, 32'h4000);
        chk("R12 ret_mem/per", {rmem, rper}, 2'b10);
        wr(4'h8, 32'h2000);
        chk("R12 ret_mem/per swap", {rmem, rper}, 2'b01);
        rd(4'h8, d); chk("R12 retention readback", d, 32'h2000);

        // R3 R4 R5 R6 sweep of the wait fields
        for (int r = 0; r < 3; r++)
            for (int f = 0; f < 3; f++)
                for (int c = 0; c < 3; c++) begin
                    run_down(r, f, c, 40);
                    run_up(r, f, c, 40);
                end
        // R3 larger waits
        run_down(2, 8, 2, 40);
        run_up(2, 8, 2, 300);

        // R7 flags cleared during the startup window
        wr(4'h0, 32'h1);
        repeat (3) @(negedge clk);
        bus_addr = 4'h4; #1;
        chk("R7 flags cleared at start", bus_rdata[16:15], 2'b00);
        bus_addr = 4'h0; #1;
        chk("R6 status held in startup", bus_rdata[31], 1);
        repeat (20) @(negedge clk);
        wr(4'h0, 32'h0);
        repeat (30) @(negedge clk);
        #1 chk("R7 back on", clken, 1);

        // R9 request change mid-sequence (c=1)
        t_off = -1; t_on = -1;
        wr(4'h0, ctl(0, 0, 1, 3'b001));
        wr(4'h0, ctl(0, 0, 1, 3'b000));
        for (int k = 2; k < 60; k++) begin
            @(negedge clk); #1;
            if (!few && t_off < 0) t_off = k + 1;
            if (t_off >= 0 && few && t_on < 0) t_on = k + 1;
        end
        chk("R9 down completes", t_off, 12);
        chk("R9 held request restores", t_on, 21);

        // R8 override
        wr(4'h0, 32'h5);
        chk("R8 outputs follow collapse", {few, rest, clken, clamp}, 4'b0001);
        chk("R8 status one cycle later (old)", bus_rdata[31], 1);
        @(negedge clk); #1;
        chk("R8 status updated", bus_rdata[31], 0);
        wr(4'h0, 32'h4);
        chk("R8 outputs restore", {few, rest, clken, clamp}, 4'b1110);
        wr(4'h0, 32'h0);
        repeat (20) @(negedge clk);
        #1 chk("R8 clearing override starts nothing", {few, clken, bus_rdata[31]}, 3'b111);

        // R11 mode change cycles the domain (waits 0)
        t_off = -1; t_on = -1;
        wr(4'h0, 32'h2);
        for (int k = 1; k < 60; k++) begin
            @(negedge clk); #1;
            if (!few && t_off < 0) t_off = k;
            if (t_off >= 0 && clken && t_on < 0) t_on = k;
        end
        chk("R11 power-down on mode change", t_off, 11);
        chk("R11 power-up after mode change", t_on, 23);

        // R10 collapse bit ignored in hardware mode
        wr(4'h0, 32'h3);
        repeat (30) @(negedge clk);
        #1 chk("R10 collapse bit ignored", {few, clken}, 2'b11);
        @(negedge clk);
        hw_req = 1'b1;
        t_off = -1;
        for (int k = 1; k < 40; k++) begin
            @(negedge clk); #1;
            if (!few && t_off < 0) t_off = k;
        end
        chk("R10 hw_req collapses", t_off, 11);
        @(negedge clk);
        hw_req = 1'b0;
        t_on = -1;
        for (int k = 1; k < 40; k++) begin
            @(negedge clk); #1;
            if (clken && t_on < 0) t_on = k;
        end
        chk("R10 hw_req release restores", t_on, 12);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule